// File: doc/BRIEF.md
# Wide-to-Narrow Unpacking FIFO

This block is a single-clock queue that stores 32-bit words and hands them out as a stream of 8-bit bytes. Each stored word is read out as four bytes. A static parameter fixes the order of those bytes: either the most significant byte leaves first, or the least significant byte leaves first. The design makes this choice explicit because converters of this kind differ in which order they use.

Writers push words through a valid/full interface and can use an early-warning flag to throttle. The reader sees a first-word-fall-through port. Whenever `empty` is low, the byte on `dout` is the current one. Asserting `rd_en` consumes that byte. A storage slot is freed only when the last of its four bytes has been read.

Top module: `wn_unpack_fifo`

## Requirements
- R1: While reset is held and directly after it, `empty` is 1, `full` is 0, `prog_full` is 0 and `dout` is 0.
- R2: With `ORDER` set to most-significant-first, the bytes of a word appear on successive accepted reads as bits [31:24], [23:16], [15:8], then [7:0].
- R3: With `ORDER` set to least-significant-first, the bytes of a word appear on successive accepted reads as bits [7:0], [15:8], [23:16], then [31:24].
- R4: A word written into an empty queue at a clock edge makes `empty` low after that same edge, and its first byte is on `dout` with no extra read latency.
- R5: A cycle without an accepted read leaves `dout` and the byte position unchanged.
- R6: `empty` rises only when the last byte of the last stored word is consumed. While `empty` is high, `dout` is 0.
- R7: `full` is high when 256 words are stored. A write while `full` is high is dropped, and the stored contents are unchanged.
- R8: A read while `empty` is high is ignored. The next word written is still delivered starting from its first byte.
- R9: `prog_full` is high exactly when 125 or more words are stored.
- R10: Words leave in the order they were written, including after the storage pointers wrap around.
- R11: Reading three of the four bytes of a word does not free its slot. `full` stays high until the fourth byte is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write request |
| din | input | 32 | Write word |
| full | output | 1 | No free word slot |
| prog_full | output | 1 | Stored word count at or above threshold |
| rd_en | input | 1 | Consume the byte shown on `dout` |
| dout | output | 8 | Current byte (first-word-fall-through) |
| empty | output | 1 | No byte available |

## Verification
Every result is due right after the clock edge that caused it, because the block has no read pipeline:
- An accepted write shows up on `empty`, `full`, `prog_full` and, for a previously empty queue, on `dout` after the edge that captured it.
- An accepted read advances `dout` after the next edge.

The bench applies inputs and compares outputs only at the falling edge. At that point it checks every output against a word queue and byte position that it keeps itself and updates at each rising edge. Two instances, one per byte order, receive the same stimulus. The stimulus runs through several phases:
- filling to full, including refused writes;
- partial draining;
- pointer wrap;
- a long mixed read/write sequence.

// File: rtl/wnu_pkg.sv
package wnu_pkg;
  typedef enum logic {
    ORDER_LSB_FIRST = 1'b0,
    ORDER_MSB_FIRST = 1'b1
  } byte_order_e;
endpackage

// File: rtl/wnu_store.sv
module wnu_store #(
  parameter int WORD_W    = 32,
  parameter int DEPTH     = 256,
  parameter int PF_THRESH = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] push_word,
  input  logic              pop,
  output logic [WORD_W-1:0] head_word,
  output logic              full,
  output logic              empty,
  output logic              prog_full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]     rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]     cnt_q, cnt_d;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push) wr_ptr_d = bump(wr_ptr_q);
    if (pop)  rd_ptr_d = bump(rd_ptr_q);
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr_q] <= push_word;
  end

  assign head_word = mem[rd_ptr_q];
  assign full      = (cnt_q == CW'(DEPTH));
  assign empty     = (cnt_q == '0);
  assign prog_full = (cnt_q >= CW'(PF_THRESH));

  // R7: a refused write leaves the write pointer where it was
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> $stable(wr_ptr_q));
  // R11: the queue leaves full only through a word pop
  p_slot_free_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full) |-> $past(pop));
  // R6: empty only rises when the final word is popped
  p_empty_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(empty) |-> $past(pop));
  // R9: the threshold flag can only rise through a write
  p_pf_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_full) |-> $past(push));
endmodule

// File: rtl/wnu_lane.sv
module wnu_lane
  import wnu_pkg::*;
#(
  parameter int          WORD_W = 32,
  parameter int          BYTE_W = 8,
  parameter byte_order_e ORDER  = ORDER_MSB_FIRST
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [WORD_W-1:0] word,
  output logic              last,
  output logic [BYTE_W-1:0] lane_byte
);
  localparam int LANES  = WORD_W / BYTE_W;
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [LANE_W-1:0] lane_q, lane_d;
  logic [LANE_W-1:0] sel;
  logic [BYTE_W-1:0] slice [LANES];

  assign last = (lane_q == LANE_W'(LANES - 1));

  always_comb begin
    lane_d = lane_q;
    if (take) lane_d = last ? '0 : lane_q + LANE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lane_q <= '0;
    else        lane_q <= lane_d;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_slice
    assign slice[g] = word[g*BYTE_W +: BYTE_W];
  end

  if (ORDER == ORDER_MSB_FIRST) begin : g_msb
    assign sel = LANE_W'(LANES - 1) - lane_q;
  end else begin : g_lsb
    assign sel = lane_q;
  end

  assign lane_byte = slice[sel];

  // R5: without an accepted read the byte position holds
  p_lane_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(lane_q));
endmodule

// File: rtl/wn_unpack_fifo.sv
module wn_unpack_fifo
  import wnu_pkg::*;
#(
  parameter int          WR_W      = 32,
  parameter int          RD_W      = 8,
  parameter int          DEPTH     = 256,
  parameter int          PF_THRESH = 125,
  parameter byte_order_e ORDER     = ORDER_MSB_FIRST
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [WR_W-1:0] din,
  output logic            full,
  output logic            prog_full,
  input  logic            rd_en,
  output logic [RD_W-1:0] dout,
  output logic            empty
);
  logic            push, take, last, pop;
  logic [WR_W-1:0] head_word;
  logic [RD_W-1:0] lane_byte;

  assign push = wr_en && !full;
  assign take = rd_en && !empty;
  assign pop  = take && last;

  wnu_store #(
    .WORD_W(WR_W), .DEPTH(DEPTH), .PF_THRESH(PF_THRESH)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .push_word(din), .pop(pop),
    .head_word(head_word), .full(full), .empty(empty), .prog_full(prog_full)
  );

  wnu_lane #(
    .WORD_W(WR_W), .BYTE_W(RD_W), .ORDER(ORDER)
  ) u_lane (
    .clk(clk), .rst_n(rst_n), .take(take), .word(head_word),
    .last(last), .lane_byte(lane_byte)
  );

  assign dout = empty ? '0 : lane_byte;

  // R5: an idle read port keeps the shown byte steady unless a write lands in an empty queue
  p_dout_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !empty) |=> $stable(dout));
endmodule

// File: tb/tb_wn_unpack_fifo.sv
module tb_wn_unpack_fifo;
  import wnu_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic rd_en = 1'b0;
  logic [31:0] din = '0;
  logic full, prog_full, empty, full_l, prog_full_l, empty_l;
  logic [7:0] dout, dout_l;

  always #2 clk = ~clk;

  wn_unpack_fifo #(.ORDER(ORDER_MSB_FIRST)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .din(din), .full(full),
    .prog_full(prog_full), .rd_en(rd_en), .dout(dout), .empty(empty));

  wn_unpack_fifo #(.ORDER(ORDER_LSB_FIRST)) dut_le (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .din(din), .full(full_l),
    .prog_full(prog_full_l), .rd_en(rd_en), .dout(dout_l), .empty(empty_l));

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [31:0] mq[$];
  int lane = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_be();
    if (mq.size() == 0) return 8'h00;
    return 8'(mq[0] >> (8 * (3 - lane)));
  endfunction

  function automatic logic [7:0] exp_le();
    if (mq.size() == 0) return 8'h00;
    return 8'(mq[0] >> (8 * lane));
  endfunction

  task automatic compare_all();
    chk("R2 msb-first dout", 32'(dout), 32'(exp_be()));
    chk("R3 lsb-first dout", 32'(dout_l), 32'(exp_le()));
    chk("R6 empty", 32'(empty), 32'(mq.size() == 0));
    chk("R6 empty lsb inst", 32'(empty_l), 32'(mq.size() == 0));
    chk("R7 full", 32'(full), 32'(mq.size() == 256));
    chk("R9 prog_full", 32'(prog_full), 32'(mq.size() >= 125));
    chk("R9 prog_full lsb inst", 32'(prog_full_l), 32'(mq.size() >= 125));
  endtask

  // one cycle: check at falling edge, drive, then model the rising edge
  task automatic cyc(input bit we, input logic [31:0] d, input bit re);
    bit wok, rok;
    @(negedge clk);
    compare_all();
    wr_en = we; din = d; rd_en = re;
    wok = we && (mq.size() < 256);
    rok = re && (mq.size() > 0);
    @(posedge clk);
    if (rok) begin
      lane++;
      if (lane == 4) begin
        void'(mq.pop_front());
        lane = 0;
      end
    end
    if (wok) mq.push_back(d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset empty", 32'(empty), 32'd1);
    chk("R1 reset full", 32'(full), 32'd0);
    chk("R1 reset prog_full", 32'(prog_full), 32'd0);
    chk("R1 reset dout", 32'(dout), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release empty", 32'(empty_l), 32'd1);
    chk("R1 after release dout", 32'(dout_l), 32'd0);

    // R8: reads on an empty queue are ignored
    repeat (3) cyc(1'b0, 32'hFFFF_FFFF, 1'b1);
    cyc(1'b1, 32'hA1B2_C3D4, 1'b0);
    cyc(1'b0, 32'h0, 1'b0);
    // R4: word visible immediately after its write edge
    chk("R4 empty low after write", 32'(empty), 32'd0);
    chk("R8 first byte msb after empty reads", 32'(dout), 32'hA1);
    chk("R8 first byte lsb after empty reads", 32'(dout_l), 32'hD4);

    // R5: reads separated by idle cycles, dout must hold
    for (int i = 0; i < 4; i++) begin
      cyc(1'b0, 32'h0, 1'b0);
      chk("R5 hold msb", 32'(dout), 32'(exp_be()));
      cyc(1'b0, 32'h0, 1'b1);
    end
    cyc(1'b0, 32'h0, 1'b0);
    chk("R6 empty after last byte", 32'(empty), 32'd1);

    // fill to full with a counting pattern, sweeping prog_full threshold
    for (int i = 0; i < 256; i++)
      cyc(1'b1, {8'(i), 8'(i ^ 8'h5A), 8'(~i), 8'(i + 3)}, 1'b0);
    cyc(1'b0, 32'h0, 1'b0);
    chk("R7 full at 256 words", 32'(full), 32'd1);
    // R7: refused writes
    for (int i = 0; i < 3; i++) cyc(1'b1, 32'hDEAD_0000 + 32'(i), 1'b0);
    // R11: three bytes read, slot still held
    for (int i = 0; i < 3; i++) cyc(1'b0, 32'h0, 1'b1);
    cyc(1'b0, 32'h0, 1'b0);
    chk("R11 full after three bytes", 32'(full), 32'd1);
    cyc(1'b0, 32'h0, 1'b1);
    cyc(1'b0, 32'h0, 1'b0);
    chk("R11 full clears after fourth byte", 32'(full), 32'd0);

    // drain, order checked each cycle (R10)
    while (mq.size() > 0) cyc(1'b0, 32'h0, 1'b1);
    cyc(1'b0, 32'h0, 1'b0);
    chk("R10 drained empty", 32'(empty), 32'd1);

    // mixed traffic across pointer wrap
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      cyc(lfsr[3] | lfsr[7], lfsr ^ 32'(i * 32'h0101_0101), lfsr[5] | (lfsr[9] & lfsr[2]));
    end
    while (mq.size() > 0) cyc(1'b0, 32'h0, 1'b1);
    cyc(1'b0, 32'h0, 1'b0);
    chk("R10 final empty", 32'(empty), 32'd1);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule